// File: doc/BRIEF.md
# Serial Configuration Write Port for a Dual-Bridge Stepper Controller

This block receives configuration words over a three-wire serial link (data, shift clock and a frame-enable strobe) and holds the settings that steer a two-bridge microstepping current controller. A host lowers the strobe, shifts in a 19-bit frame with the most significant bit first, and raises the strobe again. The last bit shifted in is the word selector. It routes the other eighteen bits into one of two internal registers: a bridge register (current codes, phases, decay modes, reference and range selection) or a timing register (blanking, off time, fast-decay time, oscillator source, rectifier mode and run/idle).

All three serial lines are asynchronous to the fast system clock. They pass through synchronizers, and their edges are detected in the system clock domain. A frame is accepted only if exactly nineteen shift-clock rising edges arrived while the strobe was low. Any other count leaves both registers untouched. Sleep and undervoltage are two separate active-low inputs, and either one returns both registers to their reset image. In that image every bit is zero except the top bit of the off-time field, so the off time is never programmed short.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, every output is 0 except `off_code`, which reads 16 (binary 10000), and `run_en` reads 0.
- R2: A frame is 19 bits, shifted most significant bit first, so frame bit 0 arrives last. A frame whose bit 0 is 1 loads the timing register and leaves the bridge outputs unchanged.
- R3: A frame whose bit 0 is 0 loads the bridge register and leaves the timing outputs unchanged.
- R4: Bridge register frame positions: `cur_code_a` = bits 6..1 (LSB at bit 1), `cur_code_b` = bits 12..7, `phase_a` = bit 13, `phase_b` = bit 14, `slow_decay_a` = bit 15, `slow_decay_b` = bit 16 (1 = slow decay, 0 = mixed), `ref_ext` = bit 17, `range_div4` = bit 18.
- R5: Timing register frame positions: `blank_sel` = bits 2..1, `off_code` = bits 7..3, `fast_code` = bits 11..8, `osc_sel` = bits 13..12, `rect_mode` = bits 15..14, `run_en` = bit 18 (0 = idle).
- R6: A frame is discarded, with both registers unchanged, when the number of shift-clock rising edges seen while the strobe was low is not exactly 19 (for example 18 or 20).
- R7: Shift-clock edges that occur while the strobe is high are neither shifted nor counted.
- R8: Timing register bits 16 and 17 are stored but affect no output.
- R9: Driving `sleep_n` or `uvlo_n` low at any time, including in the middle of a frame, restores the R1 values and abandons the partial frame.
- R10: With two synchronizer stages, the outputs take their new values on the third system clock rising edge after the strobe rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| sleep_n | input | 1 | Active-low sleep; loads the reset image |
| uvlo_n | input | 1 | Active-low undervoltage reset; loads the reset image |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_strobe | input | 1 | Frame enable; idles high and is low during a frame |
| cur_code_a | output | 6 | Current level code, bridge A |
| cur_code_b | output | 6 | Current level code, bridge B |
| phase_a | output | 1 | Current direction, bridge A |
| phase_b | output | 1 | Current direction, bridge B |
| slow_decay_a | output | 1 | Decay mode, bridge A (1 = slow, 0 = mixed) |
| slow_decay_b | output | 1 | Decay mode, bridge B (1 = slow, 0 = mixed) |
| ref_ext | output | 1 | Reference source select (1 = external) |
| range_div4 | output | 1 | Sense range select (1 = divide by 4) |
| blank_sel | output | 2 | Comparator blanking time code |
| off_code | output | 5 | Fixed off-time code |
| fast_code | output | 4 | Fast-decay portion code |
| osc_sel | output | 2 | Oscillator source and divider code |
| rect_mode | output | 2 | Synchronous rectifier mode code |
| run_en | output | 1 | 1 = run, 0 = idle |

## Verification
On every cycle, the assertions check that the shift register holds while the synchronized strobe is high, that the edge counter clears after each strobe rise and never passes its saturation value, and that each register changes only when a frame addressed to it is committed. Only the bench scenarios can show the field positions and the bit order, the reset image (including the off-time top bit set to 1), the rejection of short and long frames, the three-cycle commit latency, and abandonment of a frame by sleep or undervoltage. They do this by exhaustive sweeps of the current codes and the off-time codes, with each expected field computed from the frame the bench itself built.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int WORD_W  = 19;
   localparam int DATA_W  = WORD_W - 1;
   localparam int CODE_W  = 6;
   localparam int BLANK_W = 2;
   localparam int OFF_W   = 5;
   localparam int FAST_W  = 4;
   localparam int OSC_W   = 2;
   localparam int RECT_W  = 2;
   localparam int RSV_W   = 2;

   // frame bit positions (bit 0 is the word selector)
   localparam int P_CUR_A = 1;
   localparam int P_CUR_B = P_CUR_A + CODE_W;
   localparam int P_PH_A  = P_CUR_B + CODE_W;
   localparam int P_PH_B  = P_PH_A + 1;
   localparam int P_DEC_A = P_PH_B + 1;
   localparam int P_DEC_B = P_DEC_A + 1;
   localparam int P_REF   = P_DEC_B + 1;
   localparam int P_RNG   = P_REF + 1;

   localparam int P_BLANK = 1;
   localparam int P_OFF   = P_BLANK + BLANK_W;
   localparam int P_FAST  = P_OFF + OFF_W;
   localparam int P_OSC   = P_FAST + FAST_W;
   localparam int P_RECT  = P_OSC + OSC_W;
   localparam int P_RSV   = P_RECT + RECT_W;
   localparam int P_RUN   = P_RSV + RSV_W;

   // reset images in stored-data indexing (stored bit i = frame bit i+1)
   localparam logic [DATA_W-1:0] BRIDGE_RST = '0;
   localparam logic [DATA_W-1:0] TIMING_RST =
      DATA_W'(1) << (P_OFF + OFF_W - 2);

   typedef struct packed {
      logic [CODE_W-1:0] cur_a;
      logic [CODE_W-1:0] cur_b;
      logic              ph_a;
      logic              ph_b;
      logic              slow_a;
      logic              slow_b;
      logic              ref_ext;
      logic              rng4;
   } bridge_cfg_t;

   typedef struct packed {
      logic [BLANK_W-1:0] blank;
      logic [OFF_W-1:0]   off;
      logic [FAST_W-1:0]  fast;
      logic [OSC_W-1:0]   osc;
      logic [RECT_W-1:0]  rect;
      logic               run;
   } timing_cfg_t;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgp_shift.sv
module cfgp_shift #(
   parameter int WORD_W = 19,
   localparam int LIMIT = WORD_W + 1,
   localparam int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              strb_s,
   output logic              commit,
   output logic [WORD_W-1:0] word
);
   logic             sclk_q, strb_q;
   logic             clk_rise, strb_rise, take;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         strb_q <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         strb_q <= strb_s;
      end
   end

   assign clk_rise  = sclk_s & ~sclk_q;
   assign strb_rise = strb_s & ~strb_q;
   assign take      = clk_rise & ~strb_s;   // R7: edges with strobe high ignored

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= '0;
      else if (take) word <= {word[WORD_W-2:0], sdat_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    cnt <= '0;
      else if (strb_rise)                            cnt <= '0;
      else if (take && cnt != CNT_W'(LIMIT))         cnt <= cnt + 1'b1;
   end

   // R6: accept only a frame of exactly WORD_W edges
   assign commit = strb_rise && (cnt == CNT_W'(WORD_W));

   p_shift_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strb_s |=> $stable(word));
   p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      strb_rise |=> (cnt == '0));
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(LIMIT));
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
   import cfgp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [WORD_W-1:0] word,
   output bridge_cfg_t       bridge,
   output timing_cfg_t       timing
);
   logic [DATA_W-1:0] br_q, tm_q;
   logic              wr_br, wr_tm;

   assign wr_br = commit & ~word[0];
   assign wr_tm = commit &  word[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_q <= BRIDGE_RST;
         tm_q <= TIMING_RST;
      end else begin
         if (wr_br) br_q <= word[WORD_W-1:1];
         if (wr_tm) tm_q <= word[WORD_W-1:1];
      end
   end

   // stored bit i holds frame bit i+1
   always_comb begin
      bridge.cur_a   = br_q[P_CUR_A-1 +: CODE_W];
      bridge.cur_b   = br_q[P_CUR_B-1 +: CODE_W];
      bridge.ph_a    = br_q[P_PH_A-1];
      bridge.ph_b    = br_q[P_PH_B-1];
      bridge.slow_a  = br_q[P_DEC_A-1];
      bridge.slow_b  = br_q[P_DEC_B-1];
      bridge.ref_ext = br_q[P_REF-1];
      bridge.rng4    = br_q[P_RNG-1];
      timing.blank   = tm_q[P_BLANK-1 +: BLANK_W];
      timing.off     = tm_q[P_OFF-1 +: OFF_W];
      timing.fast    = tm_q[P_FAST-1 +: FAST_W];
      timing.osc     = tm_q[P_OSC-1 +: OSC_W];
      timing.rect    = tm_q[P_RECT-1 +: RECT_W];
      timing.run     = tm_q[P_RUN-1];
   end

   p_bridge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_br |=> $stable(br_q));
   p_timing_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_tm |=> $stable(tm_q));
   p_rsv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_tm |=> $stable(tm_q[P_RSV-1 +: RSV_W]));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfgp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              sleep_n,
   input  logic              uvlo_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_strobe,
   output logic [CODE_W-1:0] cur_code_a,
   output logic [CODE_W-1:0] cur_code_b,
   output logic              phase_a,
   output logic              phase_b,
   output logic              slow_decay_a,
   output logic              slow_decay_b,
   output logic              ref_ext,
   output logic              range_div4,
   output logic [BLANK_W-1:0] blank_sel,
   output logic [OFF_W-1:0]  off_code,
   output logic [FAST_W-1:0] fast_code,
   output logic [OSC_W-1:0]  osc_sel,
   output logic [RECT_W-1:0] rect_mode,
   output logic              run_en
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfg_serial_port: SYNC_STAGES must be at least 2");
   end
   if (P_RNG != DATA_W || P_RUN != DATA_W) begin : g_bad_map
      $error("cfg_serial_port: field map does not fill the frame");
   end

   logic        rst_n;
   logic [2:0]  line_s;
   logic        commit;
   logic [WORD_W-1:0] word;
   bridge_cfg_t bridge;
   timing_cfg_t timing;

   assign rst_n = sleep_n & uvlo_n;   // R9

   cfgp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_strobe, ser_clk, ser_data}),
      .q     (line_s)
   );

   cfgp_shift #(.WORD_W(WORD_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (line_s[1]),
      .sdat_s (line_s[0]),
      .strb_s (line_s[2]),
      .commit (commit),
      .word   (word)
   );

   cfgp_regbank u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .word   (word),
      .bridge (bridge),
      .timing (timing)
   );

   assign cur_code_a   = bridge.cur_a;
   assign cur_code_b   = bridge.cur_b;
   assign phase_a      = bridge.ph_a;
   assign phase_b      = bridge.ph_b;
   assign slow_decay_a = bridge.slow_a;
   assign slow_decay_b = bridge.slow_b;
   assign ref_ext      = bridge.ref_ext;
   assign range_div4   = bridge.rng4;
   assign blank_sel    = timing.blank;
   assign off_code     = timing.off;
   assign fast_code    = timing.fast;
   assign osc_sel      = timing.osc;
   assign rect_mode    = timing.rect;
   assign run_en       = timing.run;
endmodule

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;
   logic clk = 1'b0;
   logic sleep_n = 1'b0, uvlo_n = 1'b1;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b1;
   logic [5:0] cur_code_a, cur_code_b;
   logic phase_a, phase_b, slow_decay_a, slow_decay_b, ref_ext, range_div4;
   logic [1:0] blank_sel, osc_sel, rect_mode;
   logic [4:0] off_code;
   logic [3:0] fast_code;
   logic run_en;

   int n_vec = 0, n_bad = 0;
   bit finished = 0;
   logic [18:0] e0, e1;   // expected register frames

   always #10 clk = ~clk;   // 50 MHz

   cfg_serial_port u_cfg_serial_port (.*);

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string name, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, name, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "cur_code_a",   cur_code_a,   e0[6:1]);
      chk(req, "cur_code_b",   cur_code_b,   e0[12:7]);
      chk(req, "phase_a",      phase_a,      e0[13]);
      chk(req, "phase_b",      phase_b,      e0[14]);
      chk(req, "slow_decay_a", slow_decay_a, e0[15]);
      chk(req, "slow_decay_b", slow_decay_b, e0[16]);
      chk(req, "ref_ext",      ref_ext,      e0[17]);
      chk(req, "range_div4",   range_div4,   e0[18]);
      chk(req, "blank_sel",    blank_sel,    e1[2:1]);
      chk(req, "off_code",     off_code,     e1[7:3]);
      chk(req, "fast_code",    fast_code,    e1[11:8]);
      chk(req, "osc_sel",      osc_sel,      e1[13:12]);
      chk(req, "rect_mode",    rect_mode,    e1[15:14]);
      chk(req, "run_en",       run_en,       e1[18]);
   endtask

   // shift n edges of frame w, MSB first; bits past 19 are zero
   task automatic shift_bits(input logic [18:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         ser_data = (i < 19) ? w[18-i] : 1'b0;
         wait_n(4);
         ser_clk = 1'b1;
         wait_n(4);
         ser_clk = 1'b0;
      end
      wait_n(4);
   endtask

   task automatic send(input logic [18:0] w, input int n);
      ser_strobe = 1'b0;
      wait_n(6);
      shift_bits(w, n);
      ser_strobe = 1'b1;
      wait_n(10);
   endtask

   task automatic write_frame(input logic [18:0] w);
      send(w, 19);
      if (w[0]) e1 = w; else e0 = w;
   endtask

   function automatic logic [18:0] mk_bridge(input int k);
      logic [5:0] kk = 6'(k);
      return {kk[5], kk[4], kk[3], kk[2], kk[1], kk[0], ~kk, kk, 1'b0};
   endfunction

   function automatic logic [18:0] mk_timing(input int k, input logic [1:0] rsv);
      logic [4:0] kk = 5'(k);
      logic [3:0] f = 4'(k * 3);
      return {kk[0], rsv, kk[4:3], kk[3:2], f, kk, kk[1:0], 1'b1};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      e0 = '0;
      e1 = 19'h00080;
      wait_n(3);
      sleep_n = 1'b1;
      wait_n(5);
      check_all("R1");   // reset image, off_code = 16

      // R3/R4: sweep every current code; timing outputs must stay at reset
      for (int k = 0; k < 64; k++) begin
         write_frame(mk_bridge(k));
         check_all("R4");
      end
      check_all("R3");

      // R5/R2: sweep every off-time code; bridge outputs unchanged
      for (int k = 0; k < 32; k++) begin
         write_frame(mk_timing(k, 2'(k)));
         check_all("R5");
      end
      check_all("R2");

      // R8: reserved bits alone differ between these two frames
      write_frame(mk_timing(21, 2'b00));
      check_all("R8");
      write_frame(mk_timing(21, 2'b11));
      check_all("R8");

      // R6: short and long frames discarded
      send(mk_timing(9, 2'b01), 18);
      check_all("R6");
      send(mk_bridge(37), 18);
      check_all("R6");
      send(mk_timing(9, 2'b01), 20);
      check_all("R6");
      send(mk_bridge(37), 0);
      check_all("R6");

      // R7: 19 edges with strobe high, then an empty frame: nothing commits
      shift_bits(mk_bridge(42), 19);
      send(19'h0, 0);
      check_all("R7");

      // R10: commit latency of three system edges after strobe rises
      begin
         logic [18:0] w = mk_bridge(50);
         ser_strobe = 1'b0;
         wait_n(6);
         shift_bits(w, 19);
         ser_strobe = 1'b1;
         wait_n(2);
         chk("R10", "cur_code_a early", cur_code_a, e0[6:1]);
         wait_n(1);
         e0 = w;
         chk("R10", "cur_code_a on time", cur_code_a, e0[6:1]);
         wait_n(6);
         check_all("R10");
      end

      // R9: sleep in mid-frame abandons it and restores reset image
      write_frame(mk_timing(5, 2'b10));
      ser_strobe = 1'b0;
      wait_n(6);
      shift_bits(mk_bridge(11), 10);
      sleep_n = 1'b0;
      wait_n(3);
      sleep_n = 1'b1;
      e0 = '0;
      e1 = 19'h00080;
      check_all("R9");
      shift_bits(mk_bridge(11), 9);
      ser_strobe = 1'b1;
      wait_n(10);
      check_all("R9");

      // R9: undervoltage reset
      write_frame(mk_bridge(29));
      write_frame(mk_timing(30, 2'b00));
      uvlo_n = 1'b0;
      wait_n(3);
      uvlo_n = 1'b1;
      e0 = '0;
      e1 = 19'h00080;
      wait_n(2);
      check_all("R9");
      chk("R1", "off_code after uvlo", off_code, 16);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule